// File: doc/BRIEF.md
# Feedback Loop Delay Estimator and Adaptation Sequencer

This controller sits beside a table-based amplifier linearizer. On a start pulse it takes a block of ordinary modulated traffic: the transmit samples and the matching samples from the feedback receiver. It then searches a window of candidate lags for the one at which the feedback best matches the transmit stream. The winning lag is kept in a register and drives the alignment offset that the feedback path uses for all later adaptation.

Once the lag is known, the controller runs a fixed series of training ramps. During each ramp it counts a set number of valid samples. At the end of each ramp it raises a one-cycle request for the coefficient tables to be recomputed, and it holds off the next ramp until the solver acknowledges. Ramp samples never take part in the lag search. Compression near the top of a ramp makes a correlation over those samples unreliable, so only the traffic captured before the first ramp is used. The coefficient arithmetic and the tables themselves are outside this block.

Top module: `fb_align_sequencer`

## Requirements
- R1: After reset, and with no start pulse, captureActive, rampActive, updateReq, delayValid and seqDone stay low, alignOffset is 0, and sampleValid or updateDone activity has no effect on these outputs.
- R2: A start pulse while idle or finished begins capture on the next cycle (captureActive high). A start pulse at any other time is ignored, so capture happens exactly once per sequence.
- R3: Capture stores BLOCK_LEN+MAX_LAG consecutive valid sample pairs and skips cycles where sampleValid is low. Transmit values are kept for the first BLOCK_LEN pairs only, feedback values for all of them.
- R4: For each lag k from 0 to MAX_LAG (default 31), the block forms the signed sum over n < BLOCK_LEN of tx[n]*fb[n+k], where index 0 is the first captured pair. The lag with the largest sum becomes alignOffset.
- R5: When several lags share the largest sum, the smallest of them wins. For example, an all-zero capture yields alignOffset 0.
- R6: alignOffset does not change while delayValid is high, which covers every ramp, every update wait and the finished state. Samples arriving during ramps do not affect it.
- R7: Ramps never overlap capture. Each ramp keeps rampActive high for exactly RAMP_LEN valid samples. rampIndex counts ramps 0 to NUM_RAMPS-1 (default six ramps).
- R8: After the last sample of each ramp, updateReq is high for exactly one cycle, with rampActive low and the current ramp's rampIndex. The block then waits until updateDone is seen. An updateDone at any other time is ignored.
- R9: The acknowledgement of the last ramp's update moves the block to the finished state on the next cycle. There seqDone is high, no ramp or request occurs, and alignOffset holds the estimate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begins an estimation and adaptation sequence |
| sampleValid | input | 1 | Qualifies txSample and fbSample this cycle |
| txSample | input | DATA_W | Signed transmit-path sample (real part) |
| fbSample | input | DATA_W | Signed feedback-receiver sample (real part) |
| updateDone | input | 1 | Coefficient solver finished the requested update |
| captureActive | output | 1 | Capture window open |
| rampActive | output | 1 | Training ramp in progress |
| rampIndex | output | clog2(NUM_RAMPS) | Index of the current or last ramp |
| updateReq | output | 1 | One-cycle request to recompute the tables |
| alignOffset | output | clog2(MAX_LAG+1) | Estimated loop delay in samples |
| delayValid | output | 1 | alignOffset holds a finished estimate |
| seqDone | output | 1 | All ramps and updates complete |

## Verification
The checker checks the handshake and phase shape on every cycle. This covers the one-cycle width of updateReq, its placement outside ramps, the stability of alignOffset while valid, the separation of capture and ramp phases, the range of rampIndex, and the entry into the finished state only on an acknowledgement. Only the bench scenarios can show that the chosen lag is correct. The bench computes it from its own record of the captured samples, and covers clean delays at both ends of the window, gapped valid strobes, inverted feedback and the all-zero tie. The same holds for ramp lengths counted in valid samples, and for start pulses or stray acknowledgements that are ignored mid-sequence.

// File: rtl/fas_pkg.sv
package fas_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAPTURE,
    ST_CORRELATE,
    ST_RAMP,
    ST_UPDATE_WAIT,
    ST_DONE
  } seqState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic capWrite;   // store the current sample pair
    logic accFirst;   // first product of a lag sum
    logic accEn;      // accumulate this cycle
    logic accLast;    // last product of a lag sum: evaluate peak
  } dpCtrl_t;

endpackage

// File: rtl/fas_capture_store.sv
module fas_capture_store
  import fas_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int BLOCK_LEN = 32,
  parameter int MAX_LAG   = 31,
  localparam int FB_DEPTH = BLOCK_LEN + MAX_LAG,
  localparam int FB_AW    = $clog2(FB_DEPTH),
  localparam int N_W      = (BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1,
  localparam int LAG_W    = $clog2(MAX_LAG + 1)
) (
  input  logic                     clk,
  input  logic                     capWrite,
  input  logic [FB_AW-1:0]         capIdx,
  input  logic signed [DATA_W-1:0] txIn,
  input  logic signed [DATA_W-1:0] fbIn,
  input  logic [N_W-1:0]           sumIdx,
  input  logic [LAG_W-1:0]         lagIdx,
  output logic signed [DATA_W-1:0] txRd,
  output logic signed [DATA_W-1:0] fbRd
);

  logic signed [DATA_W-1:0] txMem [BLOCK_LEN];
  logic signed [DATA_W-1:0] fbMem [FB_DEPTH];
  logic [FB_AW-1:0]         fbAddr;

  // One write port per bank; transmit bank only fills for the first block
  generate
    for (genvar i = 0; i < FB_DEPTH; i++) begin : g_fb
      always_ff @(posedge clk) begin
        if (capWrite && capIdx == FB_AW'(i)) fbMem[i] <= fbIn;
      end
    end
    for (genvar j = 0; j < BLOCK_LEN; j++) begin : g_tx
      always_ff @(posedge clk) begin
        if (capWrite && capIdx == FB_AW'(j)) txMem[j] <= txIn;
      end
    end
  endgenerate

  assign fbAddr = FB_AW'(sumIdx) + FB_AW'(lagIdx);
  assign txRd   = txMem[sumIdx];
  assign fbRd   = fbMem[fbAddr];

endmodule

// File: rtl/fas_corr_peak.sv
module fas_corr_peak
  import fas_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int BLOCK_LEN = 32,
  parameter int MAX_LAG   = 31,
  localparam int PROD_W   = 2 * DATA_W,
  localparam int ACC_W    = PROD_W + $clog2(BLOCK_LEN) + 1,
  localparam int LAG_W    = $clog2(MAX_LAG + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     accFirst,
  input  logic                     accEn,
  input  logic                     accLast,
  input  logic [LAG_W-1:0]         lagIdx,
  input  logic signed [DATA_W-1:0] txRd,
  input  logic signed [DATA_W-1:0] fbRd,
  output logic [LAG_W-1:0]         bestLag
);

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prodExt;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  sumNext;
  logic signed [ACC_W-1:0]  bestSum;
  logic                     takePeak;

  assign prod    = txRd * fbRd;
  assign prodExt = {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};
  assign sumNext = (accFirst ? '0 : acc) + prodExt;
  // strict compare keeps the earliest lag on ties; lag 0 seeds the search
  assign takePeak = accLast && ((lagIdx == '0) || (sumNext > bestSum));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc     <= '0;
      bestSum <= '0;
      bestLag <= '0;
    end else begin
      if (accEn) acc <= sumNext;
      if (takePeak) begin
        bestSum <= sumNext;
        bestLag <= lagIdx;
      end
    end
  end

endmodule

// File: rtl/fas_datapath.sv
module fas_datapath
  import fas_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int BLOCK_LEN = 32,
  parameter int MAX_LAG   = 31,
  localparam int FB_AW    = $clog2(BLOCK_LEN + MAX_LAG),
  localparam int N_W      = (BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1,
  localparam int LAG_W    = $clog2(MAX_LAG + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpCtrl_t                  ctrl,
  input  logic [FB_AW-1:0]         capIdx,
  input  logic [N_W-1:0]           sumIdx,
  input  logic [LAG_W-1:0]         lagIdx,
  input  logic signed [DATA_W-1:0] txSample,
  input  logic signed [DATA_W-1:0] fbSample,
  output logic [LAG_W-1:0]         bestLag
);

  logic signed [DATA_W-1:0] txRd;
  logic signed [DATA_W-1:0] fbRd;

  fas_capture_store #(
    .DATA_W(DATA_W), .BLOCK_LEN(BLOCK_LEN), .MAX_LAG(MAX_LAG)
  ) u_store (
    .clk     (clk),
    .capWrite(ctrl.capWrite),
    .capIdx  (capIdx),
    .txIn    (txSample),
    .fbIn    (fbSample),
    .sumIdx  (sumIdx),
    .lagIdx  (lagIdx),
    .txRd    (txRd),
    .fbRd    (fbRd)
  );

  fas_corr_peak #(
    .DATA_W(DATA_W), .BLOCK_LEN(BLOCK_LEN), .MAX_LAG(MAX_LAG)
  ) u_peak (
    .clk     (clk),
    .rstN    (rstN),
    .accFirst(ctrl.accFirst),
    .accEn   (ctrl.accEn),
    .accLast (ctrl.accLast),
    .lagIdx  (lagIdx),
    .txRd    (txRd),
    .fbRd    (fbRd),
    .bestLag (bestLag)
  );

endmodule

// File: rtl/fas_control.sv
module fas_control
  import fas_pkg::*;
#(
  parameter int BLOCK_LEN = 32,
  parameter int MAX_LAG   = 31,
  parameter int RAMP_LEN  = 64,
  parameter int NUM_RAMPS = 6,
  localparam int FB_DEPTH = BLOCK_LEN + MAX_LAG,
  localparam int FB_AW    = $clog2(FB_DEPTH),
  localparam int N_W      = (BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1,
  localparam int LAG_W    = $clog2(MAX_LAG + 1),
  localparam int RS_W     = (RAMP_LEN > 1) ? $clog2(RAMP_LEN) : 1,
  localparam int RIDX_W   = (NUM_RAMPS > 1) ? $clog2(NUM_RAMPS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              sampleValid,
  input  logic              updateDone,
  output dpCtrl_t           ctrl,
  output logic [FB_AW-1:0]  capIdx,
  output logic [N_W-1:0]    sumIdx,
  output logic [LAG_W-1:0]  lagIdx,
  output logic              captureActive,
  output logic              rampActive,
  output logic [RIDX_W-1:0] rampIndex,
  output logic              updateReq,
  output logic              delayValid,
  output logic              seqDone
);

  localparam logic [FB_AW-1:0]  CAP_LAST  = FB_AW'(FB_DEPTH - 1);
  localparam logic [N_W-1:0]    SUM_LAST  = N_W'(BLOCK_LEN - 1);
  localparam logic [LAG_W-1:0]  LAG_LAST  = LAG_W'(MAX_LAG);
  localparam logic [RS_W-1:0]   RAMP_LAST = RS_W'(RAMP_LEN - 1);
  localparam logic [RIDX_W-1:0] IDX_LAST  = RIDX_W'(NUM_RAMPS - 1);

  seqState_t        state;
  logic [RS_W-1:0]  rampSmp;
  logic             sumEnd;

  assign sumEnd = (sumIdx == SUM_LAST);

  always_comb begin
    ctrl          = '0;
    ctrl.capWrite = (state == ST_CAPTURE) && sampleValid;
    ctrl.accEn    = (state == ST_CORRELATE);
    ctrl.accFirst = (state == ST_CORRELATE) && (sumIdx == '0);
    ctrl.accLast  = (state == ST_CORRELATE) && sumEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      capIdx    <= '0;
      sumIdx    <= '0;
      lagIdx    <= '0;
      rampSmp   <= '0;
      rampIndex <= '0;
      updateReq <= 1'b0;
    end else begin
      updateReq <= 1'b0;
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (startPulse) begin
            state     <= ST_CAPTURE;
            capIdx    <= '0;
            rampIndex <= '0;
          end
        end
        ST_CAPTURE: begin
          if (sampleValid) begin
            if (capIdx == CAP_LAST) begin
              state  <= ST_CORRELATE;
              sumIdx <= '0;
              lagIdx <= '0;
            end else begin
              capIdx <= capIdx + 1'b1;
            end
          end
        end
        ST_CORRELATE: begin
          if (sumEnd) begin
            sumIdx <= '0;
            if (lagIdx == LAG_LAST) begin
              state     <= ST_RAMP;
              rampSmp   <= '0;
              rampIndex <= '0;
            end else begin
              lagIdx <= lagIdx + 1'b1;
            end
          end else begin
            sumIdx <= sumIdx + 1'b1;
          end
        end
        ST_RAMP: begin
          if (sampleValid) begin
            if (rampSmp == RAMP_LAST) begin
              state     <= ST_UPDATE_WAIT;
              updateReq <= 1'b1;
            end else begin
              rampSmp <= rampSmp + 1'b1;
            end
          end
        end
        ST_UPDATE_WAIT: begin
          if (updateDone) begin
            if (rampIndex == IDX_LAST) begin
              state <= ST_DONE;
            end else begin
              state     <= ST_RAMP;
              rampSmp   <= '0;
              rampIndex <= rampIndex + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign captureActive = (state == ST_CAPTURE);
  assign rampActive    = (state == ST_RAMP);
  assign delayValid    = (state == ST_RAMP) || (state == ST_UPDATE_WAIT) ||
                         (state == ST_DONE);
  assign seqDone       = (state == ST_DONE);

endmodule

// File: rtl/fb_align_sequencer.sv
module fb_align_sequencer
  import fas_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int BLOCK_LEN = 32,
  parameter int MAX_LAG   = 31,
  parameter int RAMP_LEN  = 64,
  parameter int NUM_RAMPS = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     startPulse,
  input  logic                     sampleValid,
  input  logic signed [DATA_W-1:0] txSample,
  input  logic signed [DATA_W-1:0] fbSample,
  input  logic                     updateDone,
  output logic                     captureActive,
  output logic                     rampActive,
  output logic [((NUM_RAMPS > 1) ? $clog2(NUM_RAMPS) : 1)-1:0] rampIndex,
  output logic                     updateReq,
  output logic [$clog2(MAX_LAG + 1)-1:0] alignOffset,
  output logic                     delayValid,
  output logic                     seqDone
);

  localparam int FB_AW = $clog2(BLOCK_LEN + MAX_LAG);
  localparam int N_W   = (BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1;
  localparam int LAG_W = $clog2(MAX_LAG + 1);

  dpCtrl_t          ctrl;
  logic [FB_AW-1:0] capIdx;
  logic [N_W-1:0]   sumIdx;
  logic [LAG_W-1:0] lagIdx;

  fas_control #(
    .BLOCK_LEN(BLOCK_LEN), .MAX_LAG(MAX_LAG),
    .RAMP_LEN(RAMP_LEN), .NUM_RAMPS(NUM_RAMPS)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .startPulse   (startPulse),
    .sampleValid  (sampleValid),
    .updateDone   (updateDone),
    .ctrl         (ctrl),
    .capIdx       (capIdx),
    .sumIdx       (sumIdx),
    .lagIdx       (lagIdx),
    .captureActive(captureActive),
    .rampActive   (rampActive),
    .rampIndex    (rampIndex),
    .updateReq    (updateReq),
    .delayValid   (delayValid),
    .seqDone      (seqDone)
  );

  fas_datapath #(
    .DATA_W(DATA_W), .BLOCK_LEN(BLOCK_LEN), .MAX_LAG(MAX_LAG)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .capIdx  (capIdx),
    .sumIdx  (sumIdx),
    .lagIdx  (lagIdx),
    .txSample(txSample),
    .fbSample(fbSample),
    .bestLag (alignOffset)
  );

endmodule

// File: rtl/fas_checker.sv
module fas_checker #(
  parameter int MAX_LAG   = 31,
  parameter int NUM_RAMPS = 6,
  localparam int RIDX_W   = (NUM_RAMPS > 1) ? $clog2(NUM_RAMPS) : 1,
  localparam int LAG_W    = $clog2(MAX_LAG + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              updateDone,
  input logic              captureActive,
  input logic              rampActive,
  input logic [RIDX_W-1:0] rampIndex,
  input logic              updateReq,
  input logic [LAG_W-1:0]  alignOffset,
  input logic              delayValid,
  input logic              seqDone
);

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    updateReq |=> !updateReq); // R8

  AST_REQ_OUTSIDE_RAMP: assert property (@(posedge clk) disable iff (!rstN)
    updateReq |-> (!rampActive && delayValid)); // R8

  AST_OFFSET_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (delayValid && $past(delayValid)) |-> $stable(alignOffset)); // R6

  AST_PHASE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    rampActive |-> !captureActive); // R7

  AST_RAMP_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    rampActive |-> (int'(rampIndex) < NUM_RAMPS)); // R7

  AST_DONE_ON_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(seqDone) |-> $past(updateDone)); // R9

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |-> (!rampActive && !captureActive && !updateReq && delayValid)); // R9

endmodule

bind fb_align_sequencer fas_checker #(
  .MAX_LAG(MAX_LAG), .NUM_RAMPS(NUM_RAMPS)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .updateDone   (updateDone),
  .captureActive(captureActive),
  .rampActive   (rampActive),
  .rampIndex    (rampIndex),
  .updateReq    (updateReq),
  .alignOffset  (alignOffset),
  .delayValid   (delayValid),
  .seqDone      (seqDone)
);

// File: tb/fb_align_sequencer_tb.sv
module fb_align_sequencer_tb;

  localparam int DATA_W    = 12;
  localparam int BLOCK_LEN = 32;
  localparam int MAX_LAG   = 31;
  localparam int RAMP_LEN  = 16;
  localparam int NUM_RAMPS = 6;
  localparam int FB_DEPTH  = BLOCK_LEN + MAX_LAG;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                     rstN = 1'b0;
  logic                     startPulse = 1'b0;
  logic                     sampleValid = 1'b0;
  logic signed [DATA_W-1:0] txSample = '0;
  logic signed [DATA_W-1:0] fbSample = '0;
  logic                     updateDone = 1'b0;
  logic                     captureActive, rampActive, updateReq, delayValid, seqDone;
  logic [2:0]               rampIndex;
  logic [4:0]               alignOffset;

  fb_align_sequencer #(
    .DATA_W(DATA_W), .BLOCK_LEN(BLOCK_LEN), .MAX_LAG(MAX_LAG),
    .RAMP_LEN(RAMP_LEN), .NUM_RAMPS(NUM_RAMPS)
  ) u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .sampleValid(sampleValid),
    .txSample(txSample), .fbSample(fbSample), .updateDone(updateDone),
    .captureActive(captureActive), .rampActive(rampActive), .rampIndex(rampIndex),
    .updateReq(updateReq), .alignOffset(alignOffset), .delayValid(delayValid),
    .seqDone(seqDone)
  );

  typedef struct {
    int idx;
    int delay;
    int smp;
  } expItem_t;

  expItem_t expQ[$];
  int       checks = 0;
  int       fails = 0;
  bit       finished = 0;
  int       rngState = 32'h1234_5678;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int nextRand();
    rngState = rngState ^ (rngState << 13);
    rngState = rngState ^ (rngState >>> 17);
    rngState = rngState ^ (rngState << 5);
    return rngState;
  endfunction

  function automatic int randSample();
    int v;
    v = nextRand() % 2048;
    return v;
  endfunction

  // Monitor: pops expected update events as the design requests them
  initial begin
    int  smpCnt = 0;
    bit  prevReq = 0;
    expItem_t it;
    forever begin
      @(negedge clk);
      #1;
      if (rstN) begin
        if (rampActive && sampleValid) smpCnt++;
        if (updateReq) begin
          check(!prevReq, "R8", "updateReq wider than one cycle", 1, 0);
          check(!rampActive, "R8", "rampActive during request", rampActive, 0);
          if (expQ.size() == 0) begin
            check(0, "R8", "unexpected update request count", 1, 0);
          end else begin
            it = expQ.pop_front();
            check(int'(rampIndex) == it.idx, "R7", "rampIndex at request", rampIndex, it.idx);
            check(int'(alignOffset) == it.delay, "R4", "alignOffset at request", alignOffset, it.delay);
            check(smpCnt == it.smp, "R7", "valid samples in ramp", smpCnt, it.smp);
          end
          smpCnt = 0;
        end
        prevReq = updateReq;
      end
    end
  end

  task automatic runSeq(input int d, input int g, input bit gaps, input bit zero,
                        input bit disturb, input bit exact, input bit noise);
    logic signed [DATA_W-1:0] txHist [0:4095];
    int  capTx [BLOCK_LEN];
    int  capFb [FB_DEPTH];
    int  histN = 0;
    int  capN = 0;
    int  capRise = 0;
    bit  prevCap = 0;
    int  ackCnt = 0;
    int  bk = 0;
    int  iter = 0;
    bit  pushed = 0;
    bit  valid;
    int  txv, fbv;
    longint best, s;
    while (1) begin
      @(negedge clk);
      if (seqDone && iter > 1) break;
      if (iter > 20000) break;
      startPulse = (iter == 0) ||
                   (disturb && (iter == 20 || iter == 300 || (rampActive && iter % 7 == 0)));
      if (updateReq) ackCnt = 3;
      updateDone = 1'b0;
      if (ackCnt > 0) begin
        ackCnt--;
        if (ackCnt == 0) updateDone = 1'b1;
      end
      if (disturb && rampActive && iter % 5 == 0) updateDone = 1'b1;
      valid = gaps ? (iter % 4 != 3) : 1'b1;
      if (valid) begin
        txv = zero ? 0 : randSample();
        txHist[histN] = DATA_W'(txv);
        fbv = 0;
        if (!zero) begin
          if (histN >= d) fbv = (g * int'(txHist[histN - d])) / 2;
          if (noise) fbv = fbv + (nextRand() % 4);
        end
        histN++;
      end else begin
        txv = randSample();
        fbv = randSample();
      end
      sampleValid = valid;
      txSample    = DATA_W'(txv);
      fbSample    = DATA_W'(fbv);
      if (captureActive && !prevCap) capRise++;
      prevCap = captureActive;
      if (captureActive && valid && capN < FB_DEPTH) begin
        if (capN < BLOCK_LEN) capTx[capN] = txv;
        capFb[capN] = fbv;
        capN++;
      end
      if (capN == FB_DEPTH && !pushed) begin
        pushed = 1;
        best = 0;
        for (int k = 0; k <= MAX_LAG; k++) begin
          s = 0;
          for (int n = 0; n < BLOCK_LEN; n++) s += longint'(capTx[n]) * longint'(capFb[n + k]);
          if (k == 0 || s > best) begin
            best = s;
            bk = k;
          end
        end
        if (exact) check(bk == d, "R4", "model peak lag vs injected delay", bk, d);
        if (zero) check(bk == 0, "R5", "tie resolves to lag 0", bk, 0);
        for (int r = 0; r < NUM_RAMPS; r++) expQ.push_back('{r, bk, RAMP_LEN});
      end
      iter++;
    end
    startPulse = 1'b0;
    updateDone = 1'b0;
    sampleValid = 1'b0;
    #1;
    check(capN == FB_DEPTH, "R3", "captured valid pairs", capN, FB_DEPTH);
    check(capRise == 1, "R2", "capture windows per sequence", capRise, 1);
    check(seqDone == 1'b1, "R9", "seqDone after last ack", seqDone, 1);
    check(expQ.size() == 0, "R8", "outstanding update requests", expQ.size(), 0);
    check(int'(alignOffset) == bk, "R6", "offset held after ramps", alignOffset, bk);
    check(delayValid && !rampActive, "R9", "finished state outputs",
          {delayValid, rampActive}, 2);
    repeat (4) @(negedge clk);
    check(seqDone && !captureActive, "R9", "stays finished without start",
          {seqDone, captureActive}, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!captureActive && !rampActive && !updateReq && !delayValid && !seqDone,
          "R1", "outputs during reset",
          {captureActive, rampActive, updateReq, delayValid, seqDone}, 0);
    rstN = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      sampleValid = 1'b1;
      txSample = DATA_W'(randSample());
      fbSample = DATA_W'(randSample());
      updateDone = (i % 3 == 0);
    end
    sampleValid = 1'b0;
    updateDone = 1'b0;
    @(negedge clk);
    check(!captureActive && !rampActive && !updateReq && !delayValid && !seqDone,
          "R1", "idle outputs without start",
          {captureActive, rampActive, updateReq, delayValid, seqDone}, 0);
    check(alignOffset == 5'd0, "R1", "idle alignOffset", alignOffset, 0);

    runSeq(7, 1, 0, 0, 0, 1, 0);    // clean mid-window delay
    runSeq(0, 1, 1, 0, 1, 1, 1);    // gapped strobes, stray start and ack, R3 R6 R8
    runSeq(31, 1, 0, 0, 0, 1, 1);   // far edge of the window
    runSeq(12, -1, 0, 0, 0, 0, 0);  // inverted feedback, model-only peak
    runSeq(5, 1, 0, 1, 0, 0, 0);    // all-zero traffic, R5 tie

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule